// File: doc/BRIEF.md
# Three-Lead ECG Converter Sequencer

This block runs an external 10-bit analog-to-digital converter and the analog multiplexer in front of it. It samples three ECG leads one after another and repeats the order. From the 24 MHz system clock it divides down the two clocks the converter needs, a 1.2 MHz clock and a 10 kHz clock. Both have a 50% duty cycle.

When `enable` is raised, the block holds the converter in reset for a fixed number of slow-clock periods. It then loops through four steps for each lead:
- drive the lead code on the multiplexer select;
- raise a start-of-conversion pulse one fast period long;
- wait for the end-of-conversion input;
- capture the result.

The captured sample leaves on a valid/ready port together with its lead index. A result that the consumer has not accepted holds back the next conversion. A conversion whose end-of-conversion never arrives is abandoned after a bounded wait, and a one-cycle timeout pulse is raised.

Top module: `ecg_adc_seq`

## Requirements
- R1: `adc_clk_fast` is the system clock divided by 20: 10 cycles high, 10 cycles low.
- R2: `adc_clk_slow` is the system clock divided by 2400: 1200 cycles high, 1200 cycles low.
- R3: `adc_reset` stays high while `enable` is low. After `enable` rises, it stays high for at least 16 and fewer than 18 full slow-clock periods before it falls and the first conversion begins.
- R4: `adc_chsel` uses code 0 for Lead I, 1 for Lead II and 2 for Lead III. Code 3 is never driven while `adc_reset` is low. During reset the select reads 0.
- R5: Leads are converted in the order 0, 1, 2, 0, 1, 2 and so on. The first conversion after each enable uses lead 0.
- R6: `adc_chsel` is stable for at least 20 system cycles before `adc_start` rises and stays stable while it is high. `adc_start` is high for exactly 20 system cycles.
- R7: `adc_eoc` passes through a two-flop synchroniser. On its rising edge while a conversion is pending, `adc_data` is captured and presented on `out_data` with the lead code on `out_lead`, and `out_valid` is raised. `out_valid` stays high until a cycle with `out_ready` high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_lead` hold their values and no new `adc_start` pulse begins.
- R9: If no rising edge of `adc_eoc` is seen within 256 fast-clock periods after `adc_start` falls, `conv_timeout` pulses for one cycle, about 5120 system cycles after that fall. No result is produced, and the next conversion uses the following lead.
- R10: One cycle after `enable` is sampled low, `adc_reset` is high and `adc_start` is low. Acquisition restarts from R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 24 MHz |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run acquisition while high |
| adc_eoc | input | 1 | End-of-conversion from the converter (asynchronous) |
| adc_data | input | DATA_W | Conversion result, valid while `adc_eoc` is high |
| adc_clk_fast | output | 1 | 1.2 MHz converter clock |
| adc_clk_slow | output | 1 | 10 kHz converter clock |
| adc_reset | output | 1 | Converter reset |
| adc_start | output | 1 | Start-of-conversion pulse |
| adc_chsel | output | 2 | Lead select for the analog multiplexer |
| out_valid | output | 1 | Captured sample available |
| out_ready | input | 1 | Consumer accepts the sample |
| out_data | output | DATA_W | Captured sample |
| out_lead | output | 2 | Lead code of the captured sample |
| conv_timeout | output | 1 | One-cycle pulse when a conversion is abandoned |

## Verification
Each kind of internal fault shows at the ports, most within one fast-clock period:
- A wrong lead counter shows as an out-of-order `out_lead` on the next result, or as a start pulse with the wrong select.
- A wrong divider count changes the measured high and low times of the converter clocks within one of their periods.
- A broken reset counter moves the fall of `adc_reset` by whole slow periods.
- A broken wait counter moves the `conv_timeout` pulse away from its 5120-cycle position.
- A lost backpressure guard shows as an extra start pulse, or as `out_data` changing during a long stall.

// File: rtl/ecg_adc_seq.sv
module ecg_adc_seq #(
  parameter int DATA_W      = 10,
  parameter int FAST_DIV    = 20,
  parameter int SLOW_DIV    = 2400,
  parameter int RST_PERIODS = 16,
  parameter int EOC_LIMIT   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              adc_eoc,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_clk_fast,
  output logic              adc_clk_slow,
  output logic              adc_reset,
  output logic              adc_start,
  output logic [1:0]        adc_chsel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [1:0]        out_lead,
  output logic              conv_timeout
);

  localparam int FW = $clog2(FAST_DIV);
  localparam int SW = $clog2(SLOW_DIV);
  localparam int RW = $clog2(RST_PERIODS + 1);
  localparam int TW = $clog2(EOC_LIMIT);
  localparam logic [FW-1:0] FAST_LAST = FW'(FAST_DIV - 1);
  localparam logic [FW-1:0] FAST_HALF = FW'(FAST_DIV / 2 - 1);
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_DIV - 1);
  localparam logic [SW-1:0] SLOW_HALF = SW'(SLOW_DIV / 2 - 1);
  localparam logic [RW-1:0] RST_LAST  = RW'(RST_PERIODS);
  localparam logic [TW-1:0] WAIT_LAST = TW'(EOC_LIMIT - 1);
  localparam logic [1:0]    LEAD_LAST = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_SEL, S_START, S_WAIT} state_t;

  state_t        state;
  logic [FW-1:0] fast_cnt;
  logic [SW-1:0] slow_cnt;
  logic [RW-1:0] rst_cnt;
  logic [TW-1:0] wait_cnt;
  logic          sel_armed;
  logic [1:0]    lead;
  logic [2:0]    eoc_sync;

  wire fast_tick = (fast_cnt == FAST_LAST);
  wire slow_tick = (slow_cnt == SLOW_LAST);
  wire eoc_rise  = eoc_sync[1] & ~eoc_sync[2];
  wire [1:0] lead_next = (lead == LEAD_LAST) ? 2'd0 : lead + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_cnt     <= '0;
      adc_clk_fast <= 1'b0;
    end else begin
      fast_cnt <= fast_tick ? '0 : fast_cnt + 1'b1;
      if (fast_tick)                   adc_clk_fast <= 1'b1;
      else if (fast_cnt == FAST_HALF)  adc_clk_fast <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_cnt     <= '0;
      adc_clk_slow <= 1'b0;
    end else begin
      slow_cnt <= slow_tick ? '0 : slow_cnt + 1'b1;
      if (slow_tick)                   adc_clk_slow <= 1'b1;
      else if (slow_cnt == SLOW_HALF)  adc_clk_slow <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eoc_sync <= '0;
    else        eoc_sync <= {eoc_sync[1:0], adc_eoc};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      rst_cnt      <= '0;
      wait_cnt     <= '0;
      sel_armed    <= 1'b0;
      lead         <= 2'd0;
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_lead     <= 2'd0;
      conv_timeout <= 1'b0;
    end else begin
      conv_timeout <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (!enable) begin
        state <= S_IDLE;
        lead  <= 2'd0;
      end else begin
        case (state)
          S_IDLE: begin
            state   <= S_RST;
            rst_cnt <= '0;
          end
          S_RST: if (slow_tick) begin
            if (rst_cnt == RST_LAST) begin
              state     <= S_SEL;
              sel_armed <= 1'b0;
            end else begin
              rst_cnt <= rst_cnt + 1'b1;
            end
          end
          S_SEL: if (fast_tick) begin
            if (sel_armed && !out_valid) state <= S_START;
            sel_armed <= 1'b1;
          end
          S_START: if (fast_tick) begin
            state    <= S_WAIT;
            wait_cnt <= '0;
          end
          S_WAIT: begin
            if (eoc_rise) begin
              out_valid <= 1'b1;
              out_data  <= adc_data;
              out_lead  <= lead;
              lead      <= lead_next;
              state     <= S_SEL;
              sel_armed <= 1'b0;
            end else if (fast_tick) begin
              if (wait_cnt == WAIT_LAST) begin
                conv_timeout <= 1'b1;
                lead         <= lead_next;
                state        <= S_SEL;
                sel_armed    <= 1'b0;
              end else begin
                wait_cnt <= wait_cnt + 1'b1;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign adc_reset = (state == S_IDLE) || (state == S_RST);
  assign adc_start = (state == S_START);
  assign adc_chsel = adc_reset ? 2'd0 : lead;

endmodule

// File: rtl/ecg_adc_seq_chk.sv
module ecg_adc_seq_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              adc_reset,
  input logic              adc_start,
  input logic [1:0]        adc_chsel,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [1:0]        out_lead,
  input logic              conv_timeout
);

  // R4
  chsel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_reset |-> adc_chsel != 2'd3);

  // R6
  chsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> (!adc_start || $stable(adc_chsel)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_lead)));

  // R8
  no_start_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_start) |-> !out_valid);

  // R9
  timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_timeout |=> !conv_timeout);

  // R9
  timeout_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_timeout |-> !out_valid);

  // R10
  disable_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (adc_reset && !adc_start));

endmodule

bind ecg_adc_seq ecg_adc_seq_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .adc_reset(adc_reset),
  .adc_start(adc_start), .adc_chsel(adc_chsel), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_lead(out_lead),
  .conv_timeout(conv_timeout)
);

// File: tb/test_ecg_adc_seq.sv
`timescale 1ns/1ps
module test_ecg_adc_seq;
  localparam int DW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          adc_eoc;
  logic [DW-1:0] adc_data;
  logic          adc_clk_fast, adc_clk_slow, adc_reset, adc_start;
  logic [1:0]    adc_chsel;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic [1:0]    out_lead;
  logic          conv_timeout;

  int checks = 0;
  int fails  = 0;
  bit resp_on = 1'b1;
  int resp_n = 0;
  logic [1:0]    exp_lead[$];
  logic [DW-1:0] exp_data[$];

  int start_rises = 0;
  int setup_bad = 0;
  int width_bad = 0;
  int code3_bad = 0;
  int chsel_age = 1000;
  int start_len = 0;
  logic [1:0] prev_chsel = 2'd0;
  logic prev_start = 1'b0;

  always #2.5 clk = ~clk;

  ecg_adc_seq i_ecg_adc_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .adc_eoc(adc_eoc),
    .adc_data(adc_data), .adc_clk_fast(adc_clk_fast), .adc_clk_slow(adc_clk_slow),
    .adc_reset(adc_reset), .adc_start(adc_start), .adc_chsel(adc_chsel),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_lead(out_lead), .conv_timeout(conv_timeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus monitor for R4 / R6
  always @(negedge clk) begin
    if (rst_n) begin
      if (!adc_reset && adc_chsel == 2'd3) code3_bad++;
      if (adc_chsel != prev_chsel) begin
        chsel_age = 0;
        if (adc_start) setup_bad++;
      end else chsel_age++;
      if (adc_start && !prev_start) begin
        start_rises++;
        if (chsel_age < 20) setup_bad++;
        start_len = 1;
      end else if (adc_start) start_len++;
      if (!adc_start && prev_start && start_len != 20) width_bad++;
      prev_chsel = adc_chsel;
      prev_start = adc_start;
    end
  end

  // converter model
  initial begin
    adc_eoc = 1'b0;
    adc_data = '0;
    forever begin
      logic [1:0] l;
      @(negedge clk);
      while (!adc_start) @(negedge clk);
      l = adc_chsel;
      repeat (40) @(negedge clk);
      if (resp_on) begin
        adc_data = DW'(resp_n * 53 + 7 * l + 300);
        exp_lead.push_back(l);
        exp_data.push_back(adc_data);
        resp_n++;
        adc_eoc = 1'b1;
        repeat (10) @(negedge clk);
        adc_eoc = 1'b0;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  task automatic take(input string req, input int want_lead);
    logic [1:0] el;
    logic [DW-1:0] ed;
    while (!out_valid) @(negedge clk);
    el = (exp_lead.size() > 0) ? exp_lead.pop_front() : 2'd3;
    ed = (exp_data.size() > 0) ? exp_data.pop_front() : '0;
    chk(out_lead == el, {req, " R7 lead"}, out_lead, el);
    chk(out_data == ed, {req, " R7 data"}, out_data, ed);
    if (want_lead >= 0) chk(out_lead == 2'(want_lead), {req, " R5 order"}, out_lead, want_lead);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    chk(adc_reset == 1'b1, "R3 reset while disabled", adc_reset, 1);
    chk(adc_start == 1'b0, "R3 no start at reset", adc_start, 0);
    chk(adc_chsel == 2'd0, "R4 chsel in reset", adc_chsel, 0);
    chk(out_valid == 1'b0, "R7 no valid at reset", out_valid, 0);
    chk(conv_timeout == 1'b0, "R9 no timeout at reset", conv_timeout, 0);
  endtask

  task automatic measure(input string req, input bit slow, input int half);
    int hi = 0, lo = 0;
    while ((slow ? adc_clk_slow : adc_clk_fast) != 1'b0) @(negedge clk);
    while ((slow ? adc_clk_slow : adc_clk_fast) != 1'b1) @(negedge clk);
    while ((slow ? adc_clk_slow : adc_clk_fast) == 1'b1) begin hi++; @(negedge clk); end
    while ((slow ? adc_clk_slow : adc_clk_fast) == 1'b0) begin lo++; @(negedge clk); end
    chk(hi == half, {req, " high time"}, hi, half);
    chk(lo == half, {req, " low time"}, lo, half);
  endtask

  task automatic test_enable_startup(input string tag);
    int n = 0;
    enable = 1'b1;
    @(negedge clk);
    while (adc_reset) begin n++; @(negedge clk); end
    chk(n >= 16 * 2400 && n < 18 * 2400, {tag, " R3 reset hold"}, n, 16 * 2400);
    while (!adc_start) @(negedge clk);
    chk(adc_chsel == 2'd0, {tag, " R5 first lead"}, adc_chsel, 0);
  endtask

  task automatic test_round_robin();
    for (int i = 0; i < 6; i++) take("round robin", i % 3);
  endtask

  task automatic test_timeout();
    int n = 0;
    resp_on = 1'b0;
    while (!adc_start) @(negedge clk);
    chk(adc_chsel == 2'd0, "R9 timed lead", adc_chsel, 0);
    while (adc_start) @(negedge clk);
    while (!conv_timeout && n < 6000) begin n++; @(negedge clk); end
    chk(n >= 5118 && n <= 5122, "R9 timeout delay", n, 5120);
    chk(out_valid == 1'b0, "R9 no result on timeout", out_valid, 0);
    @(negedge clk);
    chk(conv_timeout == 1'b0, "R9 single pulse", conv_timeout, 0);
    resp_on = 1'b1;
    while (!adc_start) @(negedge clk);
    chk(adc_chsel == 2'd1, "R9 next lead after timeout", adc_chsel, 1);
    take("after timeout", 1);
  endtask

  task automatic test_backpressure();
    logic [DW-1:0] d0;
    logic [1:0] l0;
    int s0, moved = 0;
    while (!out_valid) @(negedge clk);
    d0 = out_data; l0 = out_lead; s0 = start_rises;
    repeat (3000) begin
      @(negedge clk);
      if (!out_valid || out_data != d0 || out_lead != l0) moved++;
    end
    chk(moved == 0, "R8 output held under stall", moved, 0);
    chk(start_rises == s0, "R8 no start under stall", start_rises - s0, 0);
    take("after stall", 2);
  endtask

  task automatic test_disable();
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(adc_reset == 1'b1, "R10 reset on disable", adc_reset, 1);
    chk(adc_start == 1'b0, "R10 no start on disable", adc_start, 0);
    chk(adc_chsel == 2'd0, "R4 chsel when disabled", adc_chsel, 0);
    test_enable_startup("re-enable R10");
    take("re-enable R10", 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    test_reset_state();
    measure("R1 fast clock", 1'b0, 10);
    measure("R2 slow clock", 1'b1, 1200);
    test_enable_startup("startup");
    test_round_robin();
    test_timeout();
    test_backpressure();
    test_disable();
    chk(code3_bad == 0, "R4 code 3 driven", code3_bad, 0);
    chk(setup_bad == 0, "R6 select setup", setup_bad, 0);
    chk(width_bad == 0, "R6 start width", width_bad, 0);
    summary();
  end
endmodule